// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block tracks the reservation for one processor. The processor uses the reservation to build an atomic read-modify-write from a load-locked, an in-register update and a store-conditional. A load-locked arms a lock flag and stores the aligned block that holds the loaded address. The lock is dropped by any of these events:
- an interrupt being taken;
- an exception;
- entry into the privileged library;
- a write from another processor that lands in the reserved block;
- the store-conditional itself.

A store-conditional is judged against the lock and the stored block. One cycle after the request, the block reports whether the store may write memory and whether it succeeded. A failed store never writes, so software loops back and retries. Cache coherence is outside this block. It only consumes the snooped write addresses that the coherence fabric delivers.

The result is registered. It is meant to drive the write-enable of the next store stage.

Top module: `llsc_monitor`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, sc_done, sc_ok and sc_wr_en are 0. A reservation that was armed before the reset is gone afterwards: a store-conditional to that block fails.
- R2: A store-conditional to the reserved block, with no cancelling event since the load-locked, gives sc_done=1, sc_ok=1 and sc_wr_en=1 in the cycle after the request.
- R3: Addresses match when they fall in the same aligned block of BLK_BYTES bytes (default 16). In other words, the bits above log2(BLK_BYTES) are equal. A different byte offset inside the block still succeeds. An address in another block fails.
- R4: A snooped remote write whose block equals the reserved block clears the lock. A remote write to any other block leaves the lock unaffected.
- R5: A taken interrupt (irq_taken=1) clears the lock.
- R6: An exception (exc_taken=1) clears the lock.
- R7: Entry into the privileged library (priv_call=1) clears the lock.
- R8: A store-conditional that fails gives sc_done=1, sc_ok=0 and sc_wr_en=0.
- R9: Every store-conditional clears the lock, whether it succeeds or fails. A second store-conditional with no new load-locked fails.
- R10: A store-conditional issued with no load-locked armed since reset fails.
- R11: A cancelling event in the same cycle as a store-conditional makes it fail. A cancelling event in the same cycle as a load-locked leaves the lock clear. For a snooped write, this holds when it hits the reserved block or the block being loaded.
- R12: A new load-locked replaces the stored block. A load-locked in the same cycle as a store-conditional arms a fresh reservation, after the store has been judged against the old one.
- R13: In a cycle that follows no store-conditional request, sc_done and sc_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_vld | input | 1 | Load-locked request |
| ll_addr | input | ADDR_W | Load-locked address |
| sc_vld | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional address |
| snp_vld | input | 1 | Remote write observed |
| snp_addr | input | ADDR_W | Remote write address |
| irq_taken | input | 1 | Interrupt taken this cycle |
| exc_taken | input | 1 | Exception taken this cycle |
| priv_call | input | 1 | Privileged-library entry this cycle |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | Store-conditional succeeded |
| sc_wr_en | output | 1 | Store may write memory |

## Verification
The bench builds the monitor with ADDR_W=16 and BLK_BYTES=16. Short addresses keep the stimulus table readable. They also put both edges of a block within easy reach: offset 0x0 against 0xF, the step into the next block at 0x10, and the topmost block at 0xFFF0. The 16-byte block exercises a compare that ignores four low bits. Same-cycle collisions are driven explicitly: an event with a load-locked, an event with a store-conditional, and a load-locked with a store-conditional.

// File: rtl/llsc_pkg.sv
// Package: shared types for the reservation monitor.
// Assumes nothing beyond being compiled first.
package llsc_pkg;

    // Cancelling causes seen in one cycle.
    typedef struct packed {
        logic irq;
        logic exc;
        logic priv;
        logic snoop_hit;
    } llsc_cancel_t;

    // Outcome of a store-conditional.
    typedef struct packed {
        logic done;
        logic ok;
        logic wr_en;
    } llsc_result_t;

endpackage

// File: rtl/llsc_blk_cmp.sv
// Block comparator: reports whether two addresses fall in the same aligned
// block of 2**OFS_W bytes. Assumes OFS_W < ADDR_W.
module llsc_blk_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_blk
);
    localparam int BLK_W = ADDR_W - OFS_W;

    logic [BLK_W-1:0] blk_a;
    logic [BLK_W-1:0] blk_b;

    // Drop the byte offset and compare the block numbers.
    always_comb begin
        blk_a    = addr_a[ADDR_W-1:OFS_W];
        blk_b    = addr_b[ADDR_W-1:OFS_W];
        same_blk = (blk_a == blk_b);
    end
endmodule

// File: rtl/llsc_cancel_merge.sv
// Cancel merge: collects the cycle's cancelling causes into one struct and
// one flag. A snooped write counts when it hits the held reservation or the
// block being loaded in the same cycle. Assumes all inputs are single-cycle.
module llsc_cancel_merge
    import llsc_pkg::*;
(
    input  logic         irq_taken,
    input  logic         exc_taken,
    input  logic         priv_call,
    input  logic         snp_vld,
    input  logic         snp_hits_held,
    input  logic         held_lock,
    input  logic         ll_vld,
    input  logic         snp_hits_new,
    output llsc_cancel_t cause,
    output logic         any_cancel
);
    // Form the cause vector and its OR.
    always_comb begin
        cause.irq       = irq_taken;
        cause.exc       = exc_taken;
        cause.priv      = priv_call;
        cause.snoop_hit = snp_vld && ((held_lock && snp_hits_held) ||
                                      (ll_vld && snp_hits_new));
        any_cancel      = cause.irq | cause.exc | cause.priv | cause.snoop_hit;
    end
endmodule

// File: rtl/llsc_resv_reg.sv
// Reservation register: holds the lock flag and the reserved block address.
// Priority: a cancel clears the lock; otherwise a load-locked arms it;
// otherwise a store-conditional clears it. Synchronous active-low reset.
module llsc_resv_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              sc_seen,
    input  logic              cancel,
    output logic              lock_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Update the lock flag under the priority above.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (cancel)  lock_q <= 1'b0;
        else if (arm)     lock_q <= 1'b1;
        else if (sc_seen) lock_q <= 1'b0;
    end

    // Capture the address on every load-locked.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (arm) addr_q <= arm_addr;
    end
endmodule

// File: rtl/llsc_monitor.sv
// Reservation monitor top: judges each store-conditional against the lock
// and stored block, and registers the result for the next store stage.
// Assumes at most one load-locked and one store-conditional per cycle, and
// that cancelling events are single-cycle pulses. Synchronous active-low reset.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_vld,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_vld,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snp_vld,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              irq_taken,
    input  logic              exc_taken,
    input  logic              priv_call,
    output logic              sc_done,
    output logic              sc_ok,
    output logic              sc_wr_en
);
    localparam int OFS_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;

    logic              lock_q;
    logic [ADDR_W-1:0] resv_addr;
    logic              sc_hit, snp_hit_held, snp_hit_new;
    logic              any_cancel;
    llsc_cancel_t      cause;
    llsc_result_t      res_d, res_q;

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cmp_sc (
        .addr_a(sc_addr), .addr_b(resv_addr), .same_blk(sc_hit)
    );
    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cmp_snp_held (
        .addr_a(snp_addr), .addr_b(resv_addr), .same_blk(snp_hit_held)
    );
    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cmp_snp_new (
        .addr_a(snp_addr), .addr_b(ll_addr), .same_blk(snp_hit_new)
    );

    llsc_cancel_merge u_merge (
        .irq_taken(irq_taken), .exc_taken(exc_taken), .priv_call(priv_call),
        .snp_vld(snp_vld), .snp_hits_held(snp_hit_held), .held_lock(lock_q),
        .ll_vld(ll_vld), .snp_hits_new(snp_hit_new),
        .cause(cause), .any_cancel(any_cancel)
    );

    llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
        .clk(clk), .rst_n(rst_n), .arm(ll_vld), .arm_addr(ll_addr),
        .sc_seen(sc_vld), .cancel(any_cancel),
        .lock_q(lock_q), .addr_q(resv_addr)
    );

    // Judge the store-conditional against the held reservation.
    always_comb begin
        res_d.done  = sc_vld;
        res_d.ok    = sc_vld && lock_q && sc_hit && !any_cancel;
        res_d.wr_en = res_d.ok;
    end

    // Register the result for the store stage.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sc_done  = res_q.done;
    assign sc_ok    = res_q.ok;
    assign sc_wr_en = res_q.wr_en;
endmodule

// File: rtl/llsc_monitor_chk.sv
// Checker: temporal properties of the reservation monitor, stated on its
// ports. Bound to every instance of llsc_monitor.
module llsc_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic ll_vld,
    input logic sc_vld,
    input logic irq_taken,
    input logic exc_taken,
    input logic priv_call,
    input logic sc_done,
    input logic sc_ok,
    input logic sc_wr_en
);
    AST_NO_RESULT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_vld |=> (!sc_done && !sc_wr_en)); // R13
    AST_FAIL_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_ok) |-> !sc_wr_en); // R8
    AST_SECOND_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && !ll_vld) ##1 sc_vld |=> !sc_ok); // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !ll_vld) ##1 sc_vld |=> !sc_ok); // R5
    AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !ll_vld) ##1 sc_vld |=> !sc_ok); // R6
    AST_PRIV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_call && !ll_vld) ##1 sc_vld |=> !sc_ok); // R7
    AST_SAME_CYCLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && (irq_taken || exc_taken || priv_call)) |=> !sc_ok); // R11
endmodule

bind llsc_monitor llsc_monitor_chk u_llsc_monitor_chk (
    .clk(clk), .rst_n(rst_n), .ll_vld(ll_vld), .sc_vld(sc_vld),
    .irq_taken(irq_taken), .exc_taken(exc_taken), .priv_call(priv_call),
    .sc_done(sc_done), .sc_ok(sc_ok), .sc_wr_en(sc_wr_en)
);

// File: tb/llsc_monitor_bench.sv
// Bench for llsc_monitor: a vector table walked one cycle per row, then
// directed reset tests. Expected results are written from the requirements.
module llsc_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    typedef struct packed {
        logic          ll;
        logic          sc;
        logic          snp;
        logic [2:0]    ev;    // {irq, exc, priv}
        logic [AW-1:0] la;
        logic [AW-1:0] sa;
        logic [AW-1:0] wa;
        logic          e_done;
        logic          e_ok;
        logic [7:0]    req;
    } vec_t;

    function automatic vec_t mk(logic ll, logic sc, logic snp, logic [2:0] ev,
                                logic [AW-1:0] la, logic [AW-1:0] sa,
                                logic [AW-1:0] wa, logic e_done, logic e_ok,
                                logic [7:0] req);
        mk = '{ll, sc, snp, ev, la, sa, wa, e_done, e_ok, req};
    endfunction

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        mk(1,0,0,3'b000,16'h1230,16'h0000,16'h0000,0,0,2),   // R2 arm
        mk(0,1,0,3'b000,16'h0000,16'h1238,16'h0000,1,1,3),   // R3 offset in block
        mk(0,1,0,3'b000,16'h0000,16'h1230,16'h0000,1,0,9),   // R9 second SC fails
        mk(0,1,0,3'b000,16'h0000,16'h4440,16'h0000,1,0,10),  // R10 no lock
        mk(1,0,0,3'b000,16'h2000,16'h0000,16'h0000,0,0,3),
        mk(0,1,0,3'b000,16'h0000,16'h2010,16'h0000,1,0,3),   // R3 next block
        mk(1,0,0,3'b000,16'h3000,16'h0000,16'h0000,0,0,4),
        mk(0,0,1,3'b000,16'h0000,16'h0000,16'h5000,0,0,4),   // R4 other block
        mk(0,1,0,3'b000,16'h0000,16'h300F,16'h0000,1,1,4),
        mk(1,0,0,3'b000,16'h3000,16'h0000,16'h0000,0,0,4),
        mk(0,0,1,3'b000,16'h0000,16'h0000,16'h300C,0,0,4),   // R4 hit
        mk(0,1,0,3'b000,16'h0000,16'h3000,16'h0000,1,0,4),
        mk(1,0,0,3'b000,16'h6000,16'h0000,16'h0000,0,0,5),
        mk(0,0,0,3'b100,16'h0000,16'h0000,16'h0000,0,0,5),   // R5 irq
        mk(0,1,0,3'b000,16'h0000,16'h6000,16'h0000,1,0,5),
        mk(1,0,0,3'b000,16'h6000,16'h0000,16'h0000,0,0,6),
        mk(0,0,0,3'b010,16'h0000,16'h0000,16'h0000,0,0,6),   // R6 exception
        mk(0,1,0,3'b000,16'h0000,16'h6000,16'h0000,1,0,6),
        mk(1,0,0,3'b000,16'h6000,16'h0000,16'h0000,0,0,7),
        mk(0,0,0,3'b001,16'h0000,16'h0000,16'h0000,0,0,7),   // R7 privileged
        mk(0,1,0,3'b000,16'h0000,16'h6000,16'h0000,1,0,8),   // R8 fail status
        mk(1,0,0,3'b100,16'h7000,16'h0000,16'h0000,0,0,11),  // R11 event with LL
        mk(0,1,0,3'b000,16'h0000,16'h7000,16'h0000,1,0,11),
        mk(1,0,0,3'b000,16'h7000,16'h0000,16'h0000,0,0,11),
        mk(0,1,1,3'b000,16'h0000,16'h7000,16'h7004,1,0,11),  // R11 snoop with SC
        mk(1,0,0,3'b000,16'h8000,16'h0000,16'h0000,0,0,12),
        mk(1,0,0,3'b000,16'h9000,16'h0000,16'h0000,0,0,12),  // R12 replace
        mk(0,1,0,3'b000,16'h0000,16'h8000,16'h0000,1,0,12),
        mk(1,0,0,3'b000,16'h9000,16'h0000,16'h0000,0,0,12),
        mk(1,1,0,3'b000,16'hA000,16'h9000,16'h0000,1,1,12),  // R12 LL with SC
        mk(0,1,0,3'b000,16'h0000,16'hA00F,16'h0000,1,1,12),
        mk(0,0,0,3'b000,16'h0000,16'h0000,16'h0000,0,0,13),  // R13 idle
        mk(1,0,0,3'b000,16'hFFF0,16'h0000,16'h0000,0,0,3),
        mk(0,1,0,3'b000,16'h0000,16'hFFFF,16'h0000,1,1,3)    // R3 top block
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ll_vld = 1'b0, sc_vld = 1'b0, snp_vld = 1'b0;
    logic irq_taken = 1'b0, exc_taken = 1'b0, priv_call = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
    logic sc_done, sc_ok, sc_wr_en;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.ADDR_W(AW), .BLK_BYTES(16)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .ll_vld(ll_vld), .ll_addr(ll_addr),
        .sc_vld(sc_vld), .sc_addr(sc_addr), .snp_vld(snp_vld),
        .snp_addr(snp_addr), .irq_taken(irq_taken), .exc_taken(exc_taken),
        .priv_call(priv_call), .sc_done(sc_done), .sc_ok(sc_ok),
        .sc_wr_en(sc_wr_en)
    );

    task automatic check(input int req, input logic e_done, input logic e_ok);
        checks++;
        if (sc_done !== e_done || sc_ok !== e_ok || sc_wr_en !== e_ok) begin
            fails++;
            $display("FAIL R%0d: done/ok/wr_en=%b%b%b expected %b%b%b",
                     req, sc_done, sc_ok, sc_wr_en, e_done, e_ok, e_ok);
        end
    endtask

    task automatic drive(input vec_t v);
        ll_vld = v.ll; sc_vld = v.sc; snp_vld = v.snp;
        {irq_taken, exc_taken, priv_call} = v.ev;
        ll_addr = v.la; sc_addr = v.sa; snp_addr = v.wa;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0);                 // R1 outputs held low in reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 1'b0);                 // R1 first cycle after reset
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i + 1 < NV) begin
                check(VECS[i].req, VECS[i].e_done, VECS[i].e_ok);
                drive(VECS[i+1]);
            end else begin
                check(VECS[i].req, VECS[i].e_done, VECS[i].e_ok);
                drive('0);
            end
        end
        // R1: a reservation armed before reset does not survive it
        drive(mk(1,0,0,3'b000,16'h1000,16'h0000,16'h0000,0,0,1));
        @(negedge clk);
        drive('0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(mk(0,1,0,3'b000,16'h0000,16'h1000,16'h0000,1,0,1));
        @(negedge clk);
        check(1, 1'b1, 1'b0);                 // R1 SC after reset fails
        drive('0);
        @(negedge clk);
        check(13, 1'b0, 1'b0);                // R13 no request, no result
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule